// File: doc/BRIEF.md
# Stepped Soft-Start Sequencer

This block times the soft start of a switching converter once its supply has crossed the turn-on level. A power-good input starts the run. Two time bases then work one after the other. A short pre-charge pulse comes first and lets an external current source lift the regulation node. A ladder of equal-length steps follows. On each step the code of an external current sink drops by one, so the regulation node can climb in stages. The last step takes the sink code to zero, which turns the sink off, and raises a done flag.

Every duration is given in nanoseconds and turned into a cycle count at elaboration, based on the clock frequency parameter. The block models only the digital controls. The analog source, sink and capacitor sit outside it.

Top module: `soft_start_seq`

## Requirements
- R1: While `rst` is high, or while `pwr_good` is low, the outputs are `precharge_en` = 0, `sink_code` = NUM_STEPS (its largest value) and `ss_done` = 0.
- R2: The first rising clock edge that samples `pwr_good` high with the block idle starts the run. Cycle 0 is the cycle after that edge. `precharge_en` is 1 in cycles 0 to PRE_CYC-1 and 0 from then on.
- R3: `sink_code` equals NUM_STEPS - floor(n / STEP_CYC) in cycle n, for 0 <= n < NUM_STEPS*STEP_CYC. Between two cycles it never rises and never falls by more than one.
- R4: From cycle NUM_STEPS*STEP_CYC onward, `sink_code` is 0 (sink off) and `ss_done` is 1. Whenever `ss_done` is 1, `sink_code` is 0.
- R5: Once `ss_done` is 1, it stays 1 for as long as `pwr_good` stays high and `rst` stays low. No new run starts during that time.
- R6: When `pwr_good` is sampled low, the outputs return to the R1 values from the next cycle on. This applies at any point in a run. The next assertion of `pwr_good` starts a complete new run from cycle 0.
- R7: PRE_CYC = floor(CLK_HZ*PRECHARGE_NS/1e9) and STEP_CYC = floor(CLK_HZ*STEP_NS/1e9). The defaults are 12 µs, 3 ms and 8 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_good | input | 1 | Supply above its turn-on level; starts the run and aborts it when it falls |
| precharge_en | output | 1 | Enable for the pre-charge current source |
| sink_code | output | $clog2(NUM_STEPS+1) | Current-sink level; 0 means the sink is off |
| ss_done | output | 1 | Soft start complete |

## Verification
The bench builds the block with CLK_HZ = 1 MHz and keeps the default durations. That gives a 12-cycle pre-charge pulse, 3000-cycle steps and a 24000-cycle run. The bench can therefore compare every cycle of complete runs against the closed-form formulas of R2 to R4. The short pulse also lets it abort a run inside the pre-charge window, in the middle of the ladder and after completion, and then follow each abort with a full second run.

// File: rtl/soft_start_seq.sv
module soft_start_seq #(
  parameter longint CLK_HZ       = 100_000_000,
  parameter longint PRECHARGE_NS = 12_000,
  parameter longint STEP_NS      = 3_000_000,
  parameter int     NUM_STEPS    = 8,
  localparam int    PRE_CYC      = int'((CLK_HZ * PRECHARGE_NS) / 64'd1_000_000_000),
  localparam int    STEP_CYC     = int'((CLK_HZ * STEP_NS) / 64'd1_000_000_000),
  localparam int    CODE_W       = $clog2(NUM_STEPS + 1),
  localparam int    PRE_W        = $clog2(PRE_CYC + 1),
  localparam int    STEP_W       = $clog2(STEP_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_good,
  output logic              precharge_en,
  output logic [CODE_W-1:0] sink_code,
  output logic              ss_done
);

  localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(NUM_STEPS);
  localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(PRE_CYC - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_CYC - 1);

  logic              running;
  logic [PRE_W-1:0]  pre_t;
  logic [STEP_W-1:0] step_t;

  wire abort    = rst || !pwr_good;
  wire start    = !running && !ss_done;
  wire step_end = running && (step_t == STEP_LAST);

  always_ff @(posedge clk) begin
    if (abort) begin
      running      <= 1'b0;
      precharge_en <= 1'b0;
      ss_done      <= 1'b0;
      sink_code    <= CODE_MAX;
      pre_t        <= '0;
      step_t       <= '0;
    end else if (start) begin
      running      <= 1'b1;
      precharge_en <= 1'b1;
      sink_code    <= CODE_MAX;
      pre_t        <= '0;
      step_t       <= '0;
    end else if (running) begin
      if (precharge_en) begin
        pre_t <= pre_t + 1'b1;
        if (pre_t == PRE_LAST) precharge_en <= 1'b0;
      end
      if (step_end) begin
        step_t    <= '0;
        sink_code <= sink_code - 1'b1;
        if (sink_code == CODE_W'(1)) begin
          running <= 1'b0;
          ss_done <= 1'b1;
        end
      end else begin
        step_t <= step_t + 1'b1;
      end
    end
  end

  initial begin
    assert (STEP_CYC > PRE_CYC && PRE_CYC > 0 && NUM_STEPS > 0);
  end

  AST_IDLE_AFTER_LOSS: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> (!precharge_en && !ss_done && sink_code == CODE_MAX)); // R6
  AST_DONE_SINK_OFF: assert property (@(posedge clk) disable iff (rst)
    ss_done |-> sink_code == '0); // R4
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (ss_done && pwr_good) |=> ss_done); // R5
  AST_CODE_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    (pwr_good && $past(pwr_good) && !$past(rst)) |-> sink_code <= $past(sink_code)); // R3
  AST_CODE_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (pwr_good && $past(pwr_good) && !$past(rst) && sink_code != $past(sink_code))
      |-> sink_code == $past(sink_code) - 1'b1); // R3
  AST_PRE_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    precharge_en |-> (sink_code == CODE_MAX && !ss_done)); // R2

endmodule

// File: tb/soft_start_seq_bench.sv
module soft_start_seq_bench;
  localparam longint CLK_HZ = 1_000_000;
  localparam int PRE   = 12;
  localparam int STEP  = 3000;
  localparam int NST   = 8;
  localparam int TOTAL = NST * STEP;

  logic clk = 1'b0, rst = 1'b1, pwr_good = 1'b0;
  logic precharge_en, ss_done;
  logic [3:0] sink_code;
  int vectors = 0, miscompares = 0;

  always #2 clk = ~clk;

  soft_start_seq #(.CLK_HZ(CLK_HZ)) u_soft_start_seq (
    .clk(clk), .rst(rst), .pwr_good(pwr_good),
    .precharge_en(precharge_en), .sink_code(sink_code), .ss_done(ss_done));

  task automatic cmp(string req, logic pe, logic [3:0] sc, logic dn, int n);
    vectors++;
    if (precharge_en !== pe || sink_code !== sc || ss_done !== dn) begin
      miscompares++;
      $display("FAIL %s n=%0d actual pre=%b code=%0d done=%b expected pre=%b code=%0d done=%b",
               req, n, precharge_en, sink_code, ss_done, pe, sc, dn);
    end
  endtask

  task automatic chk_run(int n);
    string req;
    logic [3:0] sc;
    req = (n < PRE) ? "R2/R7" : (n < TOTAL) ? "R3/R7" : "R4";
    sc  = (n < TOTAL) ? 4'(NST - n / STEP) : 4'd0;
    cmp(req, n < PRE, sc, n >= TOTAL, n);
  endtask

  task automatic chk_idle(string req);
    cmp(req, 1'b0, 4'(NST), 1'b0, -1);
  endtask

  task automatic run_until(int last);
    @(negedge clk) pwr_good = 1'b1;
    for (int n = 0; n <= last; n++) begin
      @(negedge clk);
      chk_run(n);
    end
  endtask

  task automatic drop_pg();
    pwr_good = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk_idle("R6");
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; pwr_good = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk_idle("R1");
    end
    pwr_good = 1'b0; rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk_idle("R1");
    end
  endtask

  task automatic t_full_and_hold();
    run_until(TOTAL + 2000);
    drop_pg();
  endtask

  task automatic t_abort_precharge();
    run_until(5);
    drop_pg();
    run_until(PRE + 3);
    drop_pg();
  endtask

  task automatic t_abort_ladder();
    run_until(STEP * 2 + 777);
    drop_pg();
    run_until(TOTAL + 10);
    drop_pg();
  endtask

  task automatic t_reset_mid();
    run_until(STEP + 5);
    rst = 1'b1;
    @(negedge clk);
    chk_idle("R1");
    rst = 1'b0; pwr_good = 1'b0;
    @(negedge clk);
    chk_idle("R1");
    run_until(STEP * 3);
    drop_pg();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset();
    t_full_and_hold();
    t_abort_precharge();
    t_abort_ladder();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule